// File: doc/BRIEF.md
# Timer Rate Solver

This unit converts a request of the form "source clock in hertz, wanted tick rate in hertz" into the two settings a 16-bit hardware timer needs. The first setting is a reload interval count. The second is a prescaler code. A pulse on the start input while the unit is idle captures both 32-bit operands. When the result is ready, the done output pulses for one cycle. The result then stays on the outputs until the next job finishes.

Internally the unit divides the clock by the wanted rate once, using a one-bit-per-cycle restoring divider. This gives the base ratio. The unit then tests progressively coarser prescaler settings against the width of the interval count. Each step costs one cycle and uses a right shift of the base ratio. Truncation happens once, in the divider, so a shift of the truncated ratio gives exactly the same result as dividing by the scaled rate. Ratios that are too small, and ratios that no setting can bring into range, are reported with a saturated failure encoding.

Top module: `freq_solver`

## Requirements
- R1: The base ratio is floor(in_hz / out_hz). When MIN_RATIO <= ratio < 2^IVL_W, the result is interval = ratio and prescaler code = PSC_CODES (16 by default), which means "no prescaler".
- R2: When the base ratio is below MIN_RATIO (4), the result is interval = all ones (0xFFFF) and prescaler code = all ones (0xFF).
- R3: When the base ratio is at least 2^IVL_W, codes n = 0, 1, ... PSC_CODES-1 are tried in ascending order, where code n divides by 2^(n+1). The result is the first n for which floor(in_hz / (out_hz * 2^(n+1))) < 2^IVL_W, with that quotient as the interval.
- R4: If no code from 0 to PSC_CODES-1 brings the quotient below 2^IVL_W, the result is the failure encoding of R2. With the default widths this case cannot occur.
- R5: done_o is high for exactly one cycle per accepted start. busy_o is high from the cycle after the accepting edge until done_o rises, and is low while done_o is high.
- R6: A start pulse is accepted only while busy_o and done_o are both low. The operands are captured on the accepting edge. A start during busy_o, and any later change of the operands, do not affect the pending result.
- R7: After reset, interval_o and psc_o are zero and done_o and busy_o are low. interval_o and psc_o change only on the edge that raises done_o, and hold otherwise.
- R8: done_o rises no later than CLK_W + PSC_CODES + 2 clock edges after the edge that accepts start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a solve (accepted only when idle) |
| in_hz_i | input | CLK_W | Source clock frequency |
| out_hz_i | input | CLK_W | Requested tick frequency, nonzero |
| busy_o | output | 1 | Solve in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| interval_o | output | IVL_W | Interval count result |
| psc_o | output | PSC_W | Prescaler code: n selects 2^(n+1), PSC_CODES means none, all ones means failure |

## Verification
The assertions assume two things about the inputs. The requested frequency is never zero, so the divisor invariant (remainder below divisor) is meaningful. The controller never restarts the divider while it is running, so each quotient belongs to a single operand pair. The stimulus never drives a zero rate. It launches every job only after the previous done pulse. The one exception is a deliberate mid-job start, which the idle gate must absorb. Most of the sweep runs on a narrow instance (10-bit operands, 4-bit interval, 3 codes), where the failure on exhausted codes is reachable and every branch is hit many times. A default-width instance receives directed cases.

// File: rtl/freq_solver_pkg.sv
package freq_solver_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_DIV  = 2'd1,
    FS_SCAN = 2'd2,
    FS_FIN  = 2'd3
  } fs_state_e;
endpackage

// File: rtl/fs_divider.sv
module fs_divider #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] num_i,
  input  logic [DW-1:0] den_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] quot_o
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] rem_q, quo_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic [DW:0]   shl, diff;
  logic          fits;

  assign shl  = {rem_q, quo_q[DW-1]};
  assign diff = shl - {1'b0, dvs_q};
  assign fits = ~diff[DW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && cnt_q == '0) begin
        rem_q <= '0;
        quo_q <= num_i;
        dvs_q <= den_i;
        cnt_q <= CW'(DW);
      end else if (cnt_q != '0) begin
        rem_q  <= fits ? diff[DW-1:0] : shl[DW-1:0];
        quo_q  <= {quo_q[DW-2:0], fits};
        cnt_q  <= cnt_q - 1'b1;
        done_o <= (cnt_q == CW'(1));
      end
    end
  end

  assign busy_o = (cnt_q != '0);
  assign quot_o = quo_q;

  // restart while running would corrupt the partial quotient
  p_no_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !start_i);
  p_rem_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> rem_q < dvs_q);
  p_done_after_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o));
endmodule

// File: rtl/fs_search.sv
module fs_search
  import freq_solver_pkg::*;
#(
  parameter int CLK_W     = 32,
  parameter int IVL_W     = 16,
  parameter int PSC_CODES = 16,
  parameter int PSC_W     = 8,
  parameter int MIN_RATIO = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             div_done_i,
  input  logic [CLK_W-1:0] ratio_i,
  output logic             div_start_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [IVL_W-1:0] interval_o,
  output logic [PSC_W-1:0] psc_o
);
  localparam logic [PSC_W-1:0] PSC_OFF  = PSC_W'(PSC_CODES);
  localparam logic [PSC_W-1:0] PSC_LAST = PSC_W'(PSC_CODES - 1);
  localparam logic [PSC_W-1:0] PSC_FAIL = '1;
  localparam logic [IVL_W-1:0] IVL_FAIL = '1;
  localparam bit EXHAUST_OK = (CLK_W > IVL_W + PSC_CODES);

  fs_state_e state_q, state_d;
  logic [CLK_W-1:0] shv_q, shv_d;
  logic [PSC_W-1:0] code_q, code_d;
  logic [IVL_W-1:0] ivl_d;
  logic [PSC_W-1:0] psc_d;
  logic             load_res;
  logic             ratio_fits, shv_fits, ratio_low, last_code;

  assign ratio_fits = (ratio_i[CLK_W-1:IVL_W] == '0);
  assign shv_fits   = (shv_q[CLK_W-1:IVL_W] == '0);
  assign ratio_low  = (ratio_i < CLK_W'(MIN_RATIO));

  generate
    if (EXHAUST_OK) begin : g_exhaust
      assign last_code = (code_q == PSC_LAST);
    end else begin : g_no_exhaust
      assign last_code = 1'b0;
    end
  endgenerate

  always_comb begin
    state_d  = state_q;
    shv_d    = shv_q;
    code_d   = code_q;
    ivl_d    = interval_o;
    psc_d    = psc_o;
    load_res = 1'b0;
    unique case (state_q)
      FS_IDLE: if (start_i) state_d = FS_DIV;
      FS_DIV: if (div_done_i) begin
        if (ratio_low) begin
          ivl_d = IVL_FAIL; psc_d = PSC_FAIL; load_res = 1'b1;
          state_d = FS_FIN;
        end else if (ratio_fits) begin
          ivl_d = ratio_i[IVL_W-1:0]; psc_d = PSC_OFF; load_res = 1'b1;
          state_d = FS_FIN;
        end else begin
          shv_d   = ratio_i >> 1;
          code_d  = '0;
          state_d = FS_SCAN;
        end
      end
      FS_SCAN: begin
        if (shv_fits) begin
          ivl_d = shv_q[IVL_W-1:0]; psc_d = code_q; load_res = 1'b1;
          state_d = FS_FIN;
        end else if (last_code) begin
          ivl_d = IVL_FAIL; psc_d = PSC_FAIL; load_res = 1'b1;
          state_d = FS_FIN;
        end else begin
          shv_d  = shv_q >> 1;
          code_d = code_q + 1'b1;
        end
      end
      FS_FIN: state_d = FS_IDLE;
      default: state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= FS_IDLE;
      shv_q      <= '0;
      code_q     <= '0;
      interval_o <= '0;
      psc_o      <= '0;
    end else begin
      state_q <= state_d;
      shv_q   <= shv_d;
      code_q  <= code_d;
      if (load_res) begin
        interval_o <= ivl_d;
        psc_o      <= psc_d;
      end
    end
  end

  assign div_start_o = start_i && (state_q == FS_IDLE);
  assign busy_o      = (state_q == FS_DIV) || (state_q == FS_SCAN);
  assign done_o      = (state_q == FS_FIN);

  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable({interval_o, psc_o}));
  p_psc_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (psc_o <= PSC_OFF) || (psc_o == PSC_FAIL));
  p_fail_pair_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && psc_o == PSC_FAIL) |-> (interval_o == IVL_FAIL));
  p_busy_done_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  generate
    if (!EXHAUST_OK) begin : g_chk_reach
      // with these widths the last shift always fits
      p_no_exhaust_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == FS_SCAN && code_q == PSC_LAST) |-> shv_fits);
    end
  endgenerate
endmodule

// File: rtl/freq_solver.sv
module freq_solver #(
  parameter int CLK_W     = 32,
  parameter int IVL_W     = 16,
  parameter int PSC_CODES = 16,
  parameter int PSC_W     = 8,
  parameter int MIN_RATIO = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CLK_W-1:0] in_hz_i,
  input  logic [CLK_W-1:0] out_hz_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [IVL_W-1:0] interval_o,
  output logic [PSC_W-1:0] psc_o
);
  logic             div_start, div_busy, div_done;
  logic [CLK_W-1:0] ratio;

  fs_divider #(.DW(CLK_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (div_start),
    .num_i   (in_hz_i),
    .den_i   (out_hz_i),
    .busy_o  (div_busy),
    .done_o  (div_done),
    .quot_o  (ratio)
  );

  fs_search #(
    .CLK_W(CLK_W), .IVL_W(IVL_W), .PSC_CODES(PSC_CODES),
    .PSC_W(PSC_W), .MIN_RATIO(MIN_RATIO)
  ) u_search (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .div_done_i  (div_done),
    .ratio_i     (ratio),
    .div_start_o (div_start),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .interval_o  (interval_o),
    .psc_o       (psc_o)
  );

  p_div_within_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_busy |-> busy_o);
endmodule

// File: tb/freq_solver_test.sv
module freq_solver_test;
  localparam int SW = 10, SI = 4, SC = 3;
  localparam int FW = 32, FI = 16, FC = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  // narrow instance
  logic          s_start = 1'b0;
  logic [SW-1:0] s_in = '0, s_out = '0;
  logic          s_busy, s_done;
  logic [SI-1:0] s_ivl;
  logic [7:0]    s_psc;
  // default instance
  logic          f_start = 1'b0;
  logic [FW-1:0] f_in = '0, f_out = '0;
  logic          f_busy, f_done;
  logic [FI-1:0] f_ivl;
  logic [7:0]    f_psc;

  freq_solver #(.CLK_W(SW), .IVL_W(SI), .PSC_CODES(SC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(s_start), .in_hz_i(s_in),
    .out_hz_i(s_out), .busy_o(s_busy), .done_o(s_done),
    .interval_o(s_ivl), .psc_o(s_psc));

  freq_solver uut_full (
    .clk_i(clk), .rst_ni(rst_n), .start_i(f_start), .in_hz_i(f_in),
    .out_hz_i(f_out), .busy_o(f_busy), .done_o(f_done),
    .interval_o(f_ivl), .psc_o(f_psc));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic void model(input longint c, input longint f, input int iw,
                                input int codes, output longint iv, output longint ps);
    longint r, q;
    r  = c / f;
    iv = (64'd1 << iw) - 1;
    ps = 255;
    if (r < 4) return;
    if (r < (64'd1 << iw)) begin iv = r; ps = codes; return; end
    for (int n = 0; n < codes; n++) begin
      q = c / (f * (64'd1 << (n + 1)));
      if (q < (64'd1 << iw)) begin iv = q; ps = n; return; end
    end
  endfunction

  function automatic string tag(input longint c, input longint f, input int iw, input int codes);
    longint r;
    r = c / f;
    if (r < 4) return "R2";
    if (r < (64'd1 << iw)) return "R1";
    if ((r >> codes) >= (64'd1 << iw)) return "R4";
    return "R3";
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_s(input int c, input int f);
    longint ei, ep;
    int lat;
    model(c, f, SI, SC, ei, ep);
    @(negedge clk);
    s_in = SW'(c); s_out = SW'(f); s_start = 1'b1;
    @(negedge clk);
    s_start = 1'b0;
    lat = 1;
    while (!s_done && lat < 100) begin @(negedge clk); lat++; end
    check(lat <= SW + SC + 2, "R8 latency", lat, SW + SC + 2);
    check(s_ivl == SI'(ei) && s_psc == 8'(ep), tag(c, f, SI, SC),
          {s_ivl, s_psc}, {ei[SI-1:0], ep[7:0]});
    @(negedge clk);
    check(!s_done && !s_busy, "R5 pulse", s_done, 0);
  endtask

  task automatic run_f(input longint c, input longint f);
    longint ei, ep;
    int lat;
    model(c, f, FI, FC, ei, ep);
    @(negedge clk);
    f_in = FW'(c); f_out = FW'(f); f_start = 1'b1;
    @(negedge clk);
    f_start = 1'b0;
    check(f_busy, "R5 busy", f_busy, 1);
    lat = 1;
    while (!f_done && lat < 100) begin @(negedge clk); lat++; end
    check(lat <= FW + FC + 2, "R8 latency", lat, FW + FC + 2);
    check(f_ivl == FI'(ei) && f_psc == 8'(ep), tag(c, f, FI, FC),
          {f_ivl, f_psc}, {ei[FI-1:0], ep[7:0]});
    @(negedge clk);
    check(!f_done, "R5 pulse", f_done, 0);
  endtask

  initial begin
    longint ei, ep;
    logic [FI+7:0] held;
    repeat (3) @(negedge clk);
    check(!s_done && !s_busy && s_ivl == '0 && s_psc == '0, "R7 reset",
          {s_done, s_busy, s_ivl, s_psc}, 0);
    check(!f_done && !f_busy && f_ivl == '0 && f_psc == '0, "R7 reset",
          {f_done, f_busy, f_ivl, f_psc}, 0);
    rst_n = 1'b1;

    // directed on default widths
    run_f(100_000_000, 1000);       // R3 code 0
    run_f(100_000_000, 2_000_000);  // R1 no prescaler
    run_f(100_000_000, 30_000_000); // R2 too fast
    run_f(100_000_000, 25_000_000); // R1 ratio exactly 4
    run_f(262_143, 1);              // R3 boundary, ratio 2^18-1
    run_f(262_144, 1);              // R3 code 2
    run_f(65_535, 1);               // R1 top of range
    run_f(65_536, 1);               // R3 code 0
    run_f(64'hFFFF_FFFF, 1);        // R3 last code
    run_f(0, 7);                    // R2 zero ratio
    run_f(12_345_678, 3);

    // R6: mid-job start and operand change ignored
    model(100_000_000, 1000, FI, FC, ei, ep);
    @(negedge clk);
    f_in = 100_000_000; f_out = 1000; f_start = 1'b1;
    @(negedge clk);
    f_start = 1'b0;
    repeat (4) @(negedge clk);
    f_in = 50; f_out = 1; f_start = 1'b1;
    @(negedge clk);
    f_start = 1'b0;
    while (!f_done) @(negedge clk);
    check(f_ivl == FI'(ei) && f_psc == 8'(ep), "R6 ignored start",
          {f_ivl, f_psc}, {ei[FI-1:0], ep[7:0]});
    @(negedge clk);
    check(!f_busy && !f_done, "R6 no second job", f_busy, 0);

    // R7: outputs hold while idle with new operands
    held = {f_ivl, f_psc};
    f_in = 9; f_out = 1;
    repeat (40) @(negedge clk);
    check({f_ivl, f_psc} == held, "R7 hold", {f_ivl, f_psc}, held);

    // narrow sweep: covers R1..R4 including exhausted codes
    for (int c = 0; c < (1 << SW); c += 37)
      for (int f = 1; f < 256; f++)
        run_s(c, f);
    run_s(1023, 1);
    run_s(127, 1);
    run_s(128, 1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule